// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits at the head of a receive path and decides, for every incoming frame, whether it should be kept. It watches the destination address as the first six bytes of a byte stream, the first of which is marked by a start strobe, and compares that address against a programmed station address. It also checks whether the address is the all-ones broadcast value, and looks up multicast addresses in a 64-bin hash table. The hash index is taken from a CRC-32 computed over the address while the bytes arrive. The address is never buffered for a second pass.

Software programs five 32-bit words through a simple write port: the accept-mode word, two words of station address and two words of hash table. The bytes after the address, the frame check and any data movement are handled elsewhere. One cycle after the sixth address byte the block presents a single-cycle verdict, together with three flags that classify the address. Any register written during a frame is only used from the following frame.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset `dec_valid` is low and every programmed word reads as zero, so a frame that arrives before any write is rejected while its classification flags are still reported.
- R2: When mode bit 0 (write select 0) is set, every complete frame is accepted, whatever its address.
- R3: The station address is written with select 1 (address bytes 0..3, byte 0 in data bits 7:0) and select 2 (bytes 4 and 5 in data bits 15:0). `dec_phys` is set when all six received bytes equal it, and mode bit 1 accepts such frames. Byte 0 is the first byte on the stream.
- R4: An all-ones destination sets `dec_bcast` and is accepted when mode bit 3 is set. It never sets `dec_mcast`, whatever the hash table holds.
- R5: The hash index is bits 31:26 of a CRC-32 over the six address bytes (polynomial 0x04C11DB7, register preset to all ones, each byte fed least significant bit first, no final inversion). Index 0..31 selects bit n of the word written with select 3, and index 32..63 selects bit n-32 of the word written with select 4. Mode bit 2 accepts a multicast frame whose selected bit is 1.
- R6: A destination is multicast only when bit 0 of its first byte is 1. A unicast destination never sets `dec_mcast`, even with a full hash table.
- R7: `dec_valid` is high for exactly one cycle, the cycle after the sixth address byte is taken. Idle cycles between address bytes are allowed. Bytes after the sixth produce no further verdict until the next start strobe, and the verdict outputs are all low while `dec_valid` is low.
- R8: A start strobe in the middle of an address discards the partial address and its CRC and begins a new address with that byte.
- R9: A register write takes effect only for frames whose start strobe comes after the write cycle. A write in the start-strobe cycle or later in the frame does not affect the frame in progress.
- R10: `dec_accept` is the OR of the enabled matches (and of the accept-all bit). The three flags report the address classification whatever the mode bits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select: 0 mode, 1/2 station address low/high, 3/4 hash low/high |
| cfg_wr_data | input | 32 | Register write data |
| rx_valid | input | 1 | A stream byte is present |
| rx_sof | input | 1 | The present byte is the first of a frame |
| rx_byte | input | 8 | Stream byte |
| dec_valid | output | 1 | Verdict strobe, one cycle |
| dec_accept | output | 1 | Frame accepted |
| dec_bcast | output | 1 | Destination is broadcast |
| dec_phys | output | 1 | Destination equals the station address |
| dec_mcast | output | 1 | Multicast destination that hit the hash table |

## Verification
The embedded properties check on every cycle that the verdict is a one-cycle strobe with quiet outputs between verdicts, and that the frozen mode bits stay unchanged except at a start strobe. They also check that accept-all always accepts, that broadcast and hash hits exclude each other, and that a hash hit needs the group bit and a physical match needs the stored address. The bench scenarios have to show that the CRC index and the split of the table across its two words are correct, and that the station address byte order is right. They also cover the late-write timing, the restart on a mid-address strobe, and that trailing bytes are ignored. All of these depend on values computed by the bench's own model of the address stream.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam int HASH_BINS  = 64;
    localparam int HASH_IDX_W = $clog2(HASH_BINS);
    localparam int REG_W      = 32;
    localparam int MODE_W     = 4;

    // mode bit positions
    localparam int MODE_ALL   = 0;
    localparam int MODE_PHYS  = 1;
    localparam int MODE_HASH  = 2;
    localparam int MODE_BCAST = 3;

    typedef enum logic [2:0] {
        SEL_MODE    = 3'd0,
        SEL_STA_LO  = 3'd1,
        SEL_STA_HI  = 3'd2,
        SEL_HASH_LO = 3'd3,
        SEL_HASH_HI = 3'd4
    } wsel_e;

    typedef struct packed {
        logic [MODE_W-1:0]    mode;
        logic [ADDR_W-1:0]    sta;
        logic [HASH_BINS-1:0] hash;
    } cfg_t;

endpackage

// File: rtl/rxf_crc_byte.sv
module rxf_crc_byte #(
    parameter int               CRC_W  = 32,
    parameter int               BYTE_W = 8,
    parameter logic [CRC_W-1:0] POLY   = 32'h04C1_1DB7
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);

    // one shift stage per data bit, least significant bit first
    logic [CRC_W-1:0] stage [0:BYTE_W];

    assign stage[0] = crc_in;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        logic fb;
        assign fb = stage[i][CRC_W-1] ^ data[i];
        assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[BYTE_W];

endmodule

// File: rtl/rxf_classify.sv
module rxf_classify #(
    parameter int ADDR_W    = 48,
    parameter int HASH_BINS = 64,
    parameter int MODE_W    = 4,
    localparam int IDX_W    = $clog2(HASH_BINS)
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [IDX_W-1:0]     hash_idx,
    input  logic [MODE_W-1:0]    mode,
    input  logic [ADDR_W-1:0]    sta,
    input  logic [HASH_BINS-1:0] hash,
    output logic                 is_bcast,
    output logic                 is_phys,
    output logic                 is_mcast,
    output logic                 accept
);
    import rxf_pkg::*;

    logic group_bit;
    logic hash_hit;

    always_comb begin
        group_bit = addr[0];
        hash_hit  = hash[hash_idx];
        is_bcast  = &addr;
        is_phys   = (addr == sta);
        is_mcast  = group_bit && !is_bcast && hash_hit;
        accept    = mode[MODE_ALL]
                 || (mode[MODE_PHYS]  && is_phys)
                 || (mode[MODE_HASH]  && is_mcast)
                 || (mode[MODE_BCAST] && is_bcast);
    end

endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
    import rxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [2:0]       cfg_wr_sel,
    input  logic [REG_W-1:0] cfg_wr_data,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_bcast,
    output logic             dec_phys,
    output logic             dec_mcast
);

    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;   // address bytes taken, 0 = idle
        logic [ADDR_W-1:0] addr;
        logic [CRC_W-1:0]  crc;
        cfg_t              shd;   // as written by software
        cfg_t              act;   // frozen at start of frame
        logic              dv;
        logic              acc;
        logic              bc;
        logic              ph;
        logic              mc;
    } state_t;

    state_t s_d, s_q;

    logic              take_sof;
    logic              take_cont;
    logic [CRC_W-1:0]  crc_seed;
    logic [CRC_W-1:0]  crc_nx;
    logic [ADDR_W-1:0] full_addr;
    logic              cl_bc, cl_ph, cl_mc, cl_acc;

    assign take_sof  = rx_valid && rx_sof;
    assign take_cont = rx_valid && !rx_sof && (s_q.cnt != '0) && (s_q.cnt < CNT_FULL);
    assign crc_seed  = take_sof ? '1 : s_q.crc;
    assign full_addr = {rx_byte, s_q.addr[ADDR_W-BYTE_W-1:0]};

    rxf_crc_byte #(
        .CRC_W  (CRC_W),
        .BYTE_W (BYTE_W),
        .POLY   (CRC_POLY)
    ) i_crc (
        .crc_in  (crc_seed),
        .data    (rx_byte),
        .crc_out (crc_nx)
    );

    rxf_classify #(
        .ADDR_W    (ADDR_W),
        .HASH_BINS (HASH_BINS),
        .MODE_W    (MODE_W)
    ) i_classify (
        .addr     (full_addr),
        .hash_idx (crc_nx[CRC_W-1 -: HASH_IDX_W]),
        .mode     (s_q.act.mode),
        .sta      (s_q.act.sta),
        .hash     (s_q.act.hash),
        .is_bcast (cl_bc),
        .is_phys  (cl_ph),
        .is_mcast (cl_mc),
        .accept   (cl_acc)
    );

    always_comb begin
        s_d     = s_q;
        s_d.dv  = 1'b0;
        s_d.acc = 1'b0;
        s_d.bc  = 1'b0;
        s_d.ph  = 1'b0;
        s_d.mc  = 1'b0;

        if (cfg_wr_en) begin
            case (cfg_wr_sel)
                SEL_MODE:    s_d.shd.mode = cfg_wr_data[MODE_W-1:0];
                SEL_STA_LO:  s_d.shd.sta[REG_W-1:0] = cfg_wr_data;
                SEL_STA_HI:  s_d.shd.sta[ADDR_W-1:REG_W] = cfg_wr_data[ADDR_W-REG_W-1:0];
                SEL_HASH_LO: s_d.shd.hash[REG_W-1:0] = cfg_wr_data;
                SEL_HASH_HI: s_d.shd.hash[HASH_BINS-1:REG_W] = cfg_wr_data;
                default: ;
            endcase
        end

        if (take_sof) begin
            s_d.act  = s_q.shd;
            s_d.cnt  = CNT_W'(1);
            s_d.addr = {{(ADDR_W-BYTE_W){1'b0}}, rx_byte};
            s_d.crc  = crc_nx;
        end else if (take_cont) begin
            s_d.addr[BYTE_W*s_q.cnt +: BYTE_W] = rx_byte;
            s_d.crc = crc_nx;
            s_d.cnt = s_q.cnt + CNT_W'(1);
            if (s_q.cnt == CNT_LAST) begin
                s_d.dv  = 1'b1;
                s_d.acc = cl_acc;
                s_d.bc  = cl_bc;
                s_d.ph  = cl_ph;
                s_d.mc  = cl_mc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dec_valid  = s_q.dv;
    assign dec_accept = s_q.acc;
    assign dec_bcast  = s_q.bc;
    assign dec_phys   = s_q.ph;
    assign dec_mcast  = s_q.mc;

    AST_DEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dv |=> !s_q.dv); // R7

    AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.dv |-> !(s_q.acc || s_q.bc || s_q.ph || s_q.mc)); // R7

    AST_DEC_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dv |-> $past(rx_valid && !rx_sof)); // R7

    AST_ALL_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dv && s_q.act.mode[MODE_ALL] |-> s_q.acc); // R2

    AST_PHYS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dv && s_q.ph |-> (s_q.addr == s_q.act.sta)); // R3

    AST_BCAST_NOT_HASHED: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dv && s_q.bc |-> !s_q.mc); // R4

    AST_MCAST_GROUP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dv && s_q.mc |-> s_q.addr[0]); // R6

    AST_ACCEPT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dv && s_q.acc && !s_q.act.mode[MODE_ALL] |-> (s_q.bc || s_q.ph || s_q.mc)); // R10

    AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_sof) |=> $stable(s_q.act)); // R9

endmodule

// File: tb/test_rxf_addr_filter.sv
module test_rxf_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        dec_valid, dec_accept, dec_bcast, dec_phys, dec_mcast;

    always #4 clk = ~clk; // 125 MHz

    rxf_addr_filter i_rxf_addr_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_sel  (cfg_wr_sel),
        .cfg_wr_data (cfg_wr_data),
        .rx_valid    (rx_valid),
        .rx_sof      (rx_sof),
        .rx_byte     (rx_byte),
        .dec_valid   (dec_valid),
        .dec_accept  (dec_accept),
        .dec_bcast   (dec_bcast),
        .dec_phys    (dec_phys),
        .dec_mcast   (dec_mcast)
    );

    typedef struct {
        logic  acc, bc, ph, mc;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   mon_on  = 1'b0;

    // bench model of the programmed words
    logic [3:0]  m_mode = '0;
    logic [47:0] m_sta  = '0;
    logic [63:0] m_hash = '0;

    function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    function automatic logic [31:0] m_crc(input logic [47:0] a);
        logic [31:0] c = '1;
        for (int i = 0; i < 48; i++) begin
            logic fb;
            fb = c[31] ^ a[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        return c;
    endfunction

    function automatic int m_idx(input logic [47:0] a);
        logic [31:0] c = m_crc(a);
        return int'(c[31:26]);
    endfunction

    function automatic exp_t expect_of(input logic [47:0] a, input string tag);
        exp_t e;
        e.bc  = &a;
        e.ph  = (a == m_sta);
        e.mc  = a[0] && !e.bc && m_hash[m_idx(a)];
        e.acc = m_mode[0] || (m_mode[1] && e.ph) || (m_mode[2] && e.mc) || (m_mode[3] && e.bc);
        e.tag = tag;
        return e;
    endfunction

    task automatic model_write(input logic [2:0] sel, input logic [31:0] d);
        case (sel)
            3'd0: m_mode = d[3:0];
            3'd1: m_sta[31:0] = d;
            3'd2: m_sta[47:32] = d[15:0];
            3'd3: m_hash[31:0] = d;
            3'd4: m_hash[63:32] = d;
            default: ;
        endcase
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model_write(sel, d);
    endtask

    task automatic send_frame(input logic [47:0] a, input int tail, input int gap_at,
                              input int wr_at, input logic [2:0] wsel,
                              input logic [31:0] wdat, input string tag);
        sbq.push_back(expect_of(a, tag));
        for (int i = 0; i < 6 + tail; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_byte  = (i < 6) ? a[8*i +: 8] : 8'hA5;
            cfg_wr_en   = (i == wr_at);
            cfg_wr_sel  = wsel;
            cfg_wr_data = wdat;
            if (i == gap_at) begin
                @(negedge clk);
                rx_valid = 1'b0; rx_sof = 1'b0; cfg_wr_en = 1'b0;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; cfg_wr_en = 1'b0;
        if (wr_at >= 0) model_write(wsel, wdat);
        repeat (2) @(negedge clk);
    endtask

    task automatic send(input logic [47:0] a, input string tag);
        send_frame(a, 0, -1, -1, 3'd0, 32'h0, tag);
    endtask

    task automatic send_partial(input logic [47:0] a, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = a[8*i +: 8];
        end
    endtask

    // monitor: pops one expected verdict per dec_valid strobe
    always @(negedge clk) begin
        if (mon_on && dec_valid) begin
            n_tests++;
            if (sbq.size() == 0) begin
                n_fail++;
                $display("FAIL R7: unexpected verdict acc/bc/ph/mc=%b%b%b%b expected none",
                         dec_accept, dec_bcast, dec_phys, dec_mcast);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if ({dec_accept, dec_bcast, dec_phys, dec_mcast} !== {e.acc, e.bc, e.ph, e.mc}) begin
                    n_fail++;
                    $display("FAIL %s: acc/bc/ph/mc got %b%b%b%b expected %b%b%b%b", e.tag,
                             dec_accept, dec_bcast, dec_phys, dec_mcast, e.acc, e.bc, e.ph, e.mc);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] bcast, u1, a_sta, a_bad5, a_rev, mc_lo, mc_hi, mc3;
        int idx_lo, idx_hi;
        bcast  = '1;
        u1     = mk(8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60);
        a_sta  = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        a_bad5 = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56);
        a_rev  = mk(8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02);
        mc3    = mk(8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h07);
        idx_lo = -1; idx_hi = -1; mc_lo = '0; mc_hi = '0;
        for (int x = 0; x < 256; x++) begin
            logic [47:0] c;
            c = mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'(x));
            if (idx_lo < 0 && m_idx(c) < 32) begin idx_lo = m_idx(c); mc_lo = c; end
            if (idx_hi < 0 && m_idx(c) >= 32) begin idx_hi = m_idx(c); mc_hi = c; end
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_tests++;
        if (dec_valid !== 1'b0 || dec_accept !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: after reset valid/accept got %b%b expected 00", dec_valid, dec_accept);
        end
        mon_on = 1'b1;

        send(bcast, "R1 zero config rejects");

        cfg_write(3'd0, 32'h8);
        send(bcast, "R4 broadcast accepted");
        send(u1, "R10 unicast with broadcast mode");

        cfg_write(3'd1, 32'h3322_1102);
        cfg_write(3'd2, 32'h0000_5544);
        cfg_write(3'd0, 32'h2);
        send(a_sta, "R3 station match");
        send(a_bad5, "R3 last byte differs");
        send(a_rev, "R3 reversed byte order");

        cfg_write(3'd0, 32'h4);
        send(mc_lo, "R5 empty table rejects");
        cfg_write(3'd3, 32'h1 << idx_lo);
        send(mc_lo, "R5 low word hit");
        send(mc_hi, "R5 high index misses");
        cfg_write(3'd4, 32'h1 << (idx_hi - 32));
        send(mc_hi, "R5 high word hit");

        cfg_write(3'd3, 32'hFFFF_FFFF);
        cfg_write(3'd4, 32'hFFFF_FFFF);
        send(u1, "R6 unicast never hashed");
        send(bcast, "R4 broadcast not hashed");
        send(mc3, "R6 group bit hashed");

        cfg_write(3'd0, 32'h1);
        send(u1, "R2 accept all unicast");
        cfg_write(3'd3, 32'h0);
        cfg_write(3'd4, 32'h0);
        send(mc_lo, "R2 accept all multicast miss");

        cfg_write(3'd3, 32'h1 << idx_lo);
        cfg_write(3'd0, 32'hE);
        send(a_sta, "R10 combined station");
        send(bcast, "R10 combined broadcast");
        send(mc_lo, "R10 combined multicast");
        cfg_write(3'd0, 32'h0);
        send(a_sta, "R10 flags without accept");

        cfg_write(3'd0, 32'h8);
        send_frame(bcast, 4, 2, -1, 3'd0, 32'h0, "R7 gap and trailing bytes");

        cfg_write(3'd0, 32'hA);
        send_partial(bcast, 3);
        send(a_sta, "R8 restart discards partial");

        cfg_write(3'd0, 32'h8);
        send_frame(bcast, 0, -1, 3, 3'd0, 32'h0, "R9 mid-frame write ignored");
        send(bcast, "R9 write applies next frame");
        send_frame(bcast, 0, -1, 0, 3'd0, 32'h8, "R9 write at start ignored");
        send(bcast, "R9 start write applies next");

        repeat (5) @(negedge clk);
        n_tests++;
        if (sbq.size() != 0) begin
            n_fail++;
            $display("FAIL R7: missing verdicts got %0d pending expected 0", sbq.size());
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule